// File: doc/BRIEF.md
# Timer Overflow and External Interrupt Flag Controller

This block holds the control and status byte for two 16-bit up-counters and two active-low external interrupt pins. Each counter has a run bit and an overflow flag. Each external pin has a trigger-type bit and an event flag. A single register port reads and writes the whole byte. The counters advance on a shared count-tick input. Each counter can also be preloaded through a separate load port, and its value is visible on an output.

The four interrupt sources are the two counters and the two pins. A fixed-priority selector presents the pending source with the lowest vector address, together with that vector. When the core takes a vector, it signals an acknowledge carrying the source code. This clears the matching hardware flag. A pin in low-level mode is not latched, so its request lasts only while the synchronized pin stays low.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, every control bit and both counts are zero and no request is pending. The register byte reads back {bit7 counter1 overflow, bit6 counter1 run, bit5 counter0 overflow, bit4 counter0 run, bit3 pin1 flag, bit2 pin1 type, bit1 pin0 flag, bit0 pin0 type}, and a write stores all eight bits.
- R2: When a counter whose run bit is 1 receives a tick at value FFFFh, the count becomes 0000h and its overflow flag is 1 after the same clock edge.
- R3: A counter advances by one per tick only while its run bit is 1. Clearing the run bit freezes the count without resetting it.
- R4: An acknowledge with source code 0 (pin0), 1 (counter0), 2 (pin1) or 3 (counter1) clears only the matching flag on the next edge. Other flags are unaffected.
- R5: With type bit 1, a high-to-low pin transition sets the pin's flag on the third rising edge after the pin falls (two synchronizer stages plus an edge detector). A pin that is held low does not set the flag again.
- R6: With type bit 0, the pin's request is asserted two edges after the pin goes low and is dropped two edges after it returns high. The flag bit is not set, and an acknowledge does not remove the request while the pin stays low.
- R7: The vectors are 0003h for pin0, 000Bh for counter0, 0013h for pin1 and 001Bh for counter1. When several sources are pending, the one with the lowest vector is presented.
- R8: A software write to a flag bit takes effect. A hardware set in the same cycle as a software clear leaves the flag at 1.
- R9: A load strobe writes the load value into the selected counter. The load takes precedence over a tick and never sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read data |
| tick | input | 1 | Count tick shared by both counters |
| cnt_we | input | 2 | Per-counter load strobe |
| cnt_wdata | input | 16 | Counter load value |
| cnt0_value | output | 16 | Counter 0 value |
| cnt1_value | output | 16 | Counter 1 value |
| ext_n | input | 2 | Active-low external interrupt pins |
| ack_valid | input | 1 | Core is taking a vector |
| ack_src | input | 2 | Source code being acknowledged |
| irq_pending | output | 1 | Some request is pending |
| irq_src | output | 2 | Source code of the presented request |
| irq_vector | output | 16 | Vector address of the presented request |

## Verification
Several rules are checked by assertions on every cycle. A wrap always lands at zero and raises the flag. A stopped counter with no load holds its value. An acknowledge with no competing set clears its flag. A detected edge in edge mode sets the flag. The presented source is pending, has no lower-numbered competitor, and carries the matching vector. Other behaviours are visible only through the bench's scenarios: exact synchronizer latency, a held-low pin not retriggering, a level request surviving an acknowledge, the freeze-without-reset of the count, and the precedence of a hardware set over a same-cycle write.

// File: rtl/tcon_pkg.sv
package tcon_pkg;
  localparam int NUM_CH  = 2;
  localparam int NUM_SRC = 2 * NUM_CH;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int VEC_W   = 16;

  typedef enum logic [SRC_W-1:0] {
    SRC_PIN0 = 2'd0,
    SRC_CNT0 = 2'd1,
    SRC_PIN1 = 2'd2,
    SRC_CNT1 = 2'd3
  } src_e;

  // bit positions inside the control byte, per channel index
  function automatic int bit_ovf(int ch);  return 5 + 2 * ch; endfunction
  function automatic int bit_run(int ch);  return 4 + 2 * ch; endfunction
  function automatic int bit_flag(int ch); return 1 + 2 * ch; endfunction
  function automatic int bit_type(int ch); return 2 * ch;     endfunction

  // vectors step by eight bytes starting at 0003h
  function automatic logic [VEC_W-1:0] vector_of(logic [SRC_W-1:0] s);
    return VEC_W'(16'h0003) + (VEC_W'(s) << 3);
  endfunction
endpackage

// File: rtl/tcon_counter.sv
module tcon_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         wrap_evt
);
  localparam logic [W-1:0] MAXV = '1;

  logic advance;
  assign advance  = run & tick & ~load;
  assign wrap_evt = advance & (count == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (advance) count <= count + W'(1);
  end

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0));
  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
endmodule

// File: rtl/tcon_pin_sync.sv
module tcon_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_low,
  output logic fall_evt
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign pin_low  = ~chain[STAGES-1];
  assign fall_evt = prev & ~chain[STAGES-1];

  assert_fall_from_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> !$past(pin_n, 2));
endmodule

// File: rtl/tcon_irq_select.sv
module tcon_irq_select
  import tcon_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  req,
  output logic                pending,
  output logic [SRC_W-1:0]    src,
  output logic [VEC_W-1:0]    vector
);
  logic [NUM_SRC-1:0] grant;

  always_comb begin
    grant = '0;
    src   = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (req[k]) begin
        grant = NUM_SRC'(1) << k;
        src   = SRC_W'(k);
      end
    end
  end

  assign pending = |req;
  assign vector  = pending ? vector_of(src) : '0;

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (pending == (grant != '0)));
  assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (req[src] && ((req & ((NUM_SRC'(1) << src) - NUM_SRC'(1))) == '0)));
  assert_vector_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (vector[2:0] == 3'b011 && vector[4:3] == src && vector[15:5] == '0));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tcon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             tick,
  input  logic [1:0]       cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt0_value,
  output logic [CNT_W-1:0] cnt1_value,
  input  logic [1:0]       ext_n,
  input  logic             ack_valid,
  input  logic [1:0]       ack_src,
  output logic             irq_pending,
  output logic [1:0]       irq_src,
  output logic [15:0]      irq_vector
);
  logic [NUM_CH-1:0]  ovf_q, run_q, flag_q, type_q;
  logic [NUM_CH-1:0]  wrap_evt, fall_evt, pin_low;
  logic [NUM_CH-1:0]  ack_cnt, ack_pin;
  logic [CNT_W-1:0]   count [NUM_CH];
  logic [NUM_SRC-1:0] req;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BO = bit_ovf(i);
    localparam int BR = bit_run(i);
    localparam int BF = bit_flag(i);
    localparam int BT = bit_type(i);

    tcon_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_q[i]), .tick(tick),
      .load(cnt_we[i]), .load_val(cnt_wdata),
      .count(count[i]), .wrap_evt(wrap_evt[i])
    );

    tcon_pin_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_n[i]),
      .pin_low(pin_low[i]), .fall_evt(fall_evt[i])
    );

    assign ack_cnt[i] = ack_valid && (ack_src == SRC_W'(2 * i + 1));
    assign ack_pin[i] = ack_valid && (ack_src == SRC_W'(2 * i));

    // precedence: hardware set, then software write, then acknowledge clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovf_q[i]  <= 1'b0;
        run_q[i]  <= 1'b0;
        flag_q[i] <= 1'b0;
        type_q[i] <= 1'b0;
      end else begin
        if (wrap_evt[i])     ovf_q[i] <= 1'b1;
        else if (reg_we)     ovf_q[i] <= reg_wdata[BO];
        else if (ack_cnt[i]) ovf_q[i] <= 1'b0;

        if (fall_evt[i] && type_q[i]) flag_q[i] <= 1'b1;
        else if (reg_we)              flag_q[i] <= reg_wdata[BF];
        else if (ack_pin[i])          flag_q[i] <= 1'b0;

        if (reg_we) begin
          run_q[i]  <= reg_wdata[BR];
          type_q[i] <= reg_wdata[BT];
        end
      end
    end

    assign reg_rdata[BO] = ovf_q[i];
    assign reg_rdata[BR] = run_q[i];
    assign reg_rdata[BF] = flag_q[i];
    assign reg_rdata[BT] = type_q[i];

    assign req[2 * i]     = type_q[i] ? flag_q[i] : pin_low[i];
    assign req[2 * i + 1] = ovf_q[i];

    assert_wrap_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt[i] |=> ovf_q[i]);
    assert_ack_clears_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_cnt[i] && !wrap_evt[i] && !reg_we) |=> !ovf_q[i]);
    assert_ack_clears_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pin[i] && !(fall_evt[i] && type_q[i]) && !reg_we) |=> !flag_q[i]);
    assert_edge_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt[i] && type_q[i]) |=> flag_q[i]);
  end

  assign cnt0_value = count[0];
  assign cnt1_value = count[1];

  tcon_irq_select u_sel (
    .clk(clk), .rst_n(rst_n), .req(req),
    .pending(irq_pending), .src(irq_src), .vector(irq_vector)
  );
endmodule

// File: tb/tb_tmr_irq_ctrl.sv
module tb_tmr_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, tick = 0, ack_valid = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic [1:0]  cnt_we = 0, ext_n = 2'b11, ack_src = 0, irq_src;
  logic [15:0] cnt_wdata = 0, cnt0_value, cnt1_value, irq_vector;
  logic        irq_pending;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_irq_ctrl dut (.*);

  // behavioural reference model
  bit m_s1[2], m_s2[2], m_s3[2], m_tf[2], m_tr[2], m_ie[2], m_it[2];
  int m_cnt[2];

  always @(posedge clk) begin
    bit n_tf[2], n_ie[2], fall, inc, ovf;
    cycles++;
    if (!rst_n) begin
      foreach (m_cnt[i]) begin
        m_s1[i] = 1; m_s2[i] = 1; m_s3[i] = 1;
        m_tf[i] = 0; m_tr[i] = 0; m_ie[i] = 0; m_it[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      foreach (m_cnt[i]) begin
        fall = m_s3[i] && !m_s2[i];
        inc  = m_tr[i] && tick && !cnt_we[i];
        ovf  = inc && m_cnt[i] == 65535;
        n_tf[i] = ovf ? 1 : reg_we ? reg_wdata[5+2*i]
                : (ack_valid && ack_src == 2*i+1) ? 0 : m_tf[i];
        n_ie[i] = (fall && m_it[i]) ? 1 : reg_we ? reg_wdata[1+2*i]
                : (ack_valid && ack_src == 2*i) ? 0 : m_ie[i];
        if (cnt_we[i]) m_cnt[i] = cnt_wdata;
        else if (inc)  m_cnt[i] = (m_cnt[i] + 1) % 65536;
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = ext_n[i];
      end
      foreach (m_cnt[i]) begin
        m_tf[i] = n_tf[i]; m_ie[i] = n_ie[i];
        if (reg_we) begin m_tr[i] = reg_wdata[4+2*i]; m_it[i] = reg_wdata[2*i]; end
      end
    end
  end

  function automatic int exp_rdata();
    return {m_tf[1], m_tr[1], m_tf[0], m_tr[0], m_ie[1], m_it[1], m_ie[0], m_it[0]};
  endfunction
  function automatic int exp_src();
    bit r[4];
    r[0] = m_it[0] ? m_ie[0] : !m_s2[0]; r[1] = m_tf[0];
    r[2] = m_it[1] ? m_ie[1] : !m_s2[1]; r[3] = m_tf[1];
    for (int k = 0; k < 4; k++) if (r[k]) return k;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    int s;
    s = exp_src();
    check(reg_rdata == exp_rdata(), "R1 model byte", reg_rdata, exp_rdata());
    check(cnt0_value == m_cnt[0] && cnt1_value == m_cnt[1], "R3 model counts",
          {cnt1_value, cnt0_value}, {m_cnt[1][15:0], m_cnt[0][15:0]});
    check(irq_pending == (s >= 0), "R7 model pending", irq_pending, s >= 0);
    if (s >= 0)
      check(irq_src == s && irq_vector == 3 + 8 * s, "R7 model vector", irq_vector, 3 + 8 * s);
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic load(input int ch, input logic [15:0] v);
    @(negedge clk); cnt_we[ch] = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask
  task automatic ack(input logic [1:0] s);
    @(negedge clk); ack_valid = 1; ack_src = s;
    @(negedge clk); ack_valid = 0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    idle(3); rst_n = 1; idle(1);
    check(reg_rdata == 0 && cnt0_value == 0 && !irq_pending, "R1 reset", reg_rdata, 0);
    wr(8'h45);
    check(reg_rdata == 8'h45, "R1 readback", reg_rdata, 8'h45);
    wr(8'h00);
    // R9 load and R2 wrap
    load(0, 16'hFFFD);
    check(cnt0_value == 16'hFFFD && reg_rdata == 0, "R9 load", cnt0_value, 16'hFFFD);
    wr(8'h10);
    ticks(2);
    check(cnt0_value == 16'hFFFF && reg_rdata == 8'h10, "R2 before wrap", cnt0_value, 16'hFFFF);
    ticks(1);
    check(cnt0_value == 0 && reg_rdata == 8'h30, "R2 wrap", reg_rdata, 8'h30);
    check(irq_pending && irq_src == 1 && irq_vector == 16'h000B, "R7 counter0 vector", irq_vector, 16'h000B);
    ack(2'd1);
    check(reg_rdata == 8'h10 && !irq_pending, "R4 ack counter0", reg_rdata, 8'h10);
    // R9 load beats tick, R3 freeze
    @(negedge clk); tick = 1; cnt_we = 2'b01; cnt_wdata = 16'hFFFF;
    @(negedge clk); tick = 0; cnt_we = 0;
    check(cnt0_value == 16'hFFFF && reg_rdata == 8'h10, "R9 load over tick", cnt0_value, 16'hFFFF);
    load(0, 16'h1234);
    wr(8'h00);
    ticks(5);
    check(cnt0_value == 16'h1234, "R3 frozen", cnt0_value, 16'h1234);
    wr(8'h10);
    ticks(2);
    check(cnt0_value == 16'h1236, "R3 resumes", cnt0_value, 16'h1236);
    // R8 hardware set wins over software clear
    load(0, 16'hFFFF);
    @(negedge clk); reg_we = 1; reg_wdata = 8'h00; tick = 1;
    @(negedge clk); reg_we = 0; tick = 0;
    check(reg_rdata == 8'h20 && cnt0_value == 0, "R8 set beats clear", reg_rdata, 8'h20);
    ack(2'd1);
    // R8 software sets, R7 ordering, R4 selective
    wr(8'h80);
    check(irq_pending && irq_vector == 16'h001B, "R8 sw set counter1", irq_vector, 16'h001B);
    wr(8'hA0);
    check(irq_src == 1, "R7 lowest first", irq_src, 1);
    ack(2'd1);
    check(reg_rdata == 8'h80 && irq_src == 3, "R4 other flag kept", reg_rdata, 8'h80);
    wr(8'h00);
    // R5 edge mode on pin0
    wr(8'h01);
    @(negedge clk); ext_n[0] = 0;
    idle(2);
    check(reg_rdata == 8'h01, "R5 not yet", reg_rdata, 8'h01);
    idle(1);
    check(reg_rdata == 8'h03 && irq_vector == 16'h0003, "R5 edge latched", reg_rdata, 8'h03);
    ack(2'd0);
    idle(4);
    check(reg_rdata == 8'h01 && !irq_pending, "R5 held low no retrigger", reg_rdata, 8'h01);
    @(negedge clk); ext_n[0] = 1;
    idle(3);
    // R6 level mode on pin1
    wr(8'h00);
    @(negedge clk); ext_n[1] = 0;
    idle(2);
    check(irq_pending && irq_vector == 16'h0013 && reg_rdata == 0, "R6 level request", irq_vector, 16'h0013);
    ack(2'd2);
    idle(1);
    check(irq_pending && irq_src == 2, "R6 ack no effect", irq_src, 2);
    @(negedge clk); ext_n[0] = 0;
    idle(3);
    check(irq_src == 0, "R7 pin0 over pin1", irq_src, 0);
    @(negedge clk); ext_n = 2'b11;
    idle(2);
    check(!irq_pending && reg_rdata == 0, "R6 released", irq_pending, 0);
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule